// File: doc/BRIEF.md
# Asynchronous SRAM controller

This block sits between a synchronous host and an external asynchronous static RAM with a 16-bit data path. The host raises a request with a read/write flag, a 20-bit word address, write data and a byte mask. The controller runs the whole memory access on its own and reports completion with a one-cycle done pulse. A read returns the selected lanes in the same pulse. Every external timing interval comes from a picosecond parameter. Each is turned into a whole number of system clock cycles, rounded up.

On the memory side the block drives:

- two chip selects of opposite polarity;
- a write strobe and an output-enable strobe, both active low;
- one active-low select per byte lane;
- a 16-bit data path, split into an output value, an output-enable for the pad, and an input value.

Each access steps through an address setup phase and then an active phase. A write then has a hold phase. A read then has a bus-turnaround phase, during which the memory's outputs float before the controller may drive the bus again. A request with an empty byte mask completes at once and the memory pins do not move.

Top module: `sram_ctrl`

## Requirements
- R1: While rst_ni is low and right after it rises: ready_o=1, done_o=0, mem_cs1_no=1, mem_cs2_o=0, mem_we_no=1, mem_oe_no=1, mem_be_no all ones, mem_dq_oe_o=0.
- R2: The memory is selected (mem_cs1_no=0 and mem_cs2_o=1 together) only during the setup, active and hold phases of an access. Whenever ready_o is 1, it is deselected and all strobes are inactive.
- R3: A read keeps mem_oe_no low with mem_we_no high for RD_CYC cycles (3 by default), after a 1-cycle setup. On the cycle after the last one, done_o pulses. rdata_o then carries the memory data for the enabled lanes and zero for the lanes that are not enabled.
- R4: A write drives mem_dq_o, the address and the byte selects for one setup cycle with mem_we_no high. It then holds mem_we_no low for WR_CYC cycles (2 by default), then keeps the data driven for one hold cycle with mem_we_no high. done_o pulses in the cycle after the hold phase, together with ready_o.
- R5: be_i bit 0 enables data bits 7:0 and bit 1 enables bits 15:8. mem_be_no[i] is low exactly while the memory is selected for an access whose be_i[i] was 1.
- R6: A request accepted with be_i=0 gives done_o=1 in the next cycle and ready_o stays 1. No memory pin changes.
- R7: After mem_oe_no rises, mem_dq_oe_o stays low for at least TA_CYC cycles (2 by default). During those cycles ready_o is 0.
- R8: req_i is ignored while ready_o is 0. A request made during an access starts no access and writes nothing.
- R9: done_o lasts one cycle per completed access.
- R10: mem_we_no and mem_oe_no are never low together.
- R11: mem_addr_o holds the accepted address and does not change while the memory is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | system clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| req_i | input | 1 | access request, sampled when ready_o is 1 |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 20 | word address |
| wdata_i | input | 16 | write data |
| be_i | input | 2 | lane enables, bit 0 = low byte |
| ready_o | output | 1 | controller idle, request accepted |
| done_o | output | 1 | one-cycle completion pulse |
| rdata_o | output | 16 | read data, valid with done_o |
| mem_addr_o | output | 20 | memory address |
| mem_cs1_no | output | 1 | chip select, active low |
| mem_cs2_o | output | 1 | chip select, active high |
| mem_we_no | output | 1 | write strobe, active low |
| mem_oe_no | output | 1 | output enable, active low |
| mem_be_no | output | 2 | lane selects, active low, bit 0 = bits 7:0 |
| mem_dq_o | output | 16 | data to the pad |
| mem_dq_oe_o | output | 1 | pad drive enable |
| mem_dq_i | input | 16 | data from the pad |

## Verification
The hardest situation to reach is a write that follows a read as closely as the host allows. This is the only case where a missing or short turnaround would let both sides drive the bus together. The bench issues writes directly after reads. Its memory model counts the float window after output enable rises and flags any pad drive inside that window. The memory model also returns garbage until output enable has been low long enough. A shortened read count is therefore caught in the read data. Requests pulsed in the middle of a busy access, to a neighbouring address, show through a later read-back that nothing was written.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_ACTIVE,
    PH_HOLD,
    PH_TURN
  } phase_e;

  function automatic int unsigned ps_to_cyc(int unsigned t_ps, int unsigned clk_ps);
    return (t_ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == '0);
endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned LANES     = 2,
  parameter int unsigned CNT_W     = 3,
  parameter int unsigned SETUP_CYC = 1,
  parameter int unsigned RD_CYC    = 3,
  parameter int unsigned WR_CYC    = 2,
  parameter int unsigned HOLD_CYC  = 1,
  parameter int unsigned TA_CYC    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [LANES-1:0] be_i,
  output logic             ready_o,
  output logic             done_o,
  output logic             accept_o,
  output logic             capture_o,
  output logic             sel_d_o,
  output logic             sel_o,
  output logic             we_o,
  output logic             oe_o,
  output logic             drv_o
);
  phase_e st_q, st_d;
  logic wr_q, wr_d, done_d, done_q;
  logic sel_q, we_q, oe_q, drv_q;
  logic ld, last;
  logic [CNT_W-1:0] ld_val;

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ld),
    .load_val_i (ld_val),
    .last_o     (last)
  );

  always_comb begin
    st_d      = st_q;
    wr_d      = wr_q;
    ld        = 1'b0;
    ld_val    = '0;
    accept_o  = 1'b0;
    capture_o = 1'b0;
    done_d    = 1'b0;
    unique case (st_q)
      PH_IDLE: if (req_i) begin
        if (be_i == '0) begin
          done_d = 1'b1;               // empty mask: complete without bus activity
        end else begin
          accept_o = 1'b1;
          wr_d     = we_i;
          st_d     = PH_SETUP;
          ld       = 1'b1;
          ld_val   = CNT_W'(SETUP_CYC - 1);
        end
      end
      PH_SETUP: if (last) begin
        st_d   = PH_ACTIVE;
        ld     = 1'b1;
        ld_val = wr_q ? CNT_W'(WR_CYC - 1) : CNT_W'(RD_CYC - 1);
      end
      PH_ACTIVE: if (last) begin
        ld = 1'b1;
        if (wr_q) begin
          st_d   = PH_HOLD;
          ld_val = CNT_W'(HOLD_CYC - 1);
        end else begin
          st_d      = PH_TURN;
          ld_val    = CNT_W'(TA_CYC - 1);
          capture_o = 1'b1;
          done_d    = 1'b1;
        end
      end
      PH_HOLD: if (last) begin
        st_d   = PH_IDLE;
        done_d = 1'b1;
      end
      PH_TURN: if (last) st_d = PH_IDLE;
      default: st_d = PH_IDLE;
    endcase
  end

  assign sel_d_o = (st_d == PH_SETUP) || (st_d == PH_ACTIVE) || (st_d == PH_HOLD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= PH_IDLE;
      wr_q   <= 1'b0;
      done_q <= 1'b0;
      sel_q  <= 1'b0;
      we_q   <= 1'b0;
      oe_q   <= 1'b0;
      drv_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      wr_q   <= wr_d;
      done_q <= done_d;
      sel_q  <= sel_d_o;
      we_q   <= (st_d == PH_ACTIVE) && wr_d;
      oe_q   <= (st_d == PH_ACTIVE) && !wr_d;
      drv_q  <= sel_d_o && wr_d;
    end
  end

  assign ready_o = (st_q == PH_IDLE);
  assign done_o  = done_q;
  assign sel_o   = sel_q;
  assign we_o    = we_q;
  assign oe_o    = oe_q;
  assign drv_o   = drv_q;
endmodule

// File: rtl/sram_lane.sv
module sram_lane #(
  parameter int unsigned LANE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              en_i,
  input  logic [LANE_W-1:0] wdata_i,
  input  logic              capture_i,
  input  logic              sel_d_i,
  input  logic [LANE_W-1:0] dq_i,
  output logic              bsel_n_o,
  output logic [LANE_W-1:0] wdata_o,
  output logic [LANE_W-1:0] rdata_o
);
  logic en_q, bsel_n_q;
  logic [LANE_W-1:0] wd_q, rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      bsel_n_q <= 1'b1;
      wd_q     <= '0;
      rd_q     <= '0;
    end else begin
      if (accept_i) begin
        en_q <= en_i;
        wd_q <= wdata_i;
      end
      bsel_n_q <= !(sel_d_i && (accept_i ? en_i : en_q));
      if (capture_i) rd_q <= en_q ? dq_i : '0;
    end
  end

  assign bsel_n_o = bsel_n_q;
  assign wdata_o  = wd_q;
  assign rdata_o  = rd_q;
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W  = 20,
  parameter int unsigned LANES   = 2,
  parameter int unsigned LANE_W  = 8,
  parameter int unsigned CLK_PS  = 10000,
  parameter int unsigned T_AA_PS = 25000,
  parameter int unsigned T_WP_PS = 20000,
  parameter int unsigned T_DW_PS = 15000,
  parameter int unsigned T_HZ_PS = 12000,
  parameter int unsigned T_AS_PS = 0,
  parameter int unsigned T_DH_PS = 0
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_i,
  input  logic                      we_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [LANES*LANE_W-1:0]   wdata_i,
  input  logic [LANES-1:0]          be_i,
  output logic                      ready_o,
  output logic                      done_o,
  output logic [LANES*LANE_W-1:0]   rdata_o,
  output logic [ADDR_W-1:0]         mem_addr_o,
  output logic                      mem_cs1_no,
  output logic                      mem_cs2_o,
  output logic                      mem_we_no,
  output logic                      mem_oe_no,
  output logic [LANES-1:0]          mem_be_no,
  output logic [LANES*LANE_W-1:0]   mem_dq_o,
  output logic                      mem_dq_oe_o,
  input  logic [LANES*LANE_W-1:0]   mem_dq_i
);
  localparam int unsigned SETUP_CYC = 1 + ps_to_cyc(T_AS_PS, CLK_PS);
  localparam int unsigned RD_CYC    = max2(1, ps_to_cyc(T_AA_PS, CLK_PS));
  localparam int unsigned WR_CYC    = max2(1, max2(ps_to_cyc(T_WP_PS, CLK_PS),
                                                   ps_to_cyc(T_DW_PS, CLK_PS)));
  localparam int unsigned HOLD_CYC  = 1 + ps_to_cyc(T_DH_PS, CLK_PS);
  localparam int unsigned TA_CYC    = max2(1, ps_to_cyc(T_HZ_PS, CLK_PS));
  localparam int unsigned MAX_CYC   = max2(max2(SETUP_CYC, RD_CYC),
                                           max2(max2(WR_CYC, HOLD_CYC), TA_CYC));
  localparam int unsigned CNT_W     = $clog2(MAX_CYC + 1);

  logic accept, capture, sel_d, sel, we_act, oe_act, drv;
  logic [ADDR_W-1:0] addr_q;

  sram_ctrl_fsm #(
    .LANES(LANES), .CNT_W(CNT_W), .SETUP_CYC(SETUP_CYC), .RD_CYC(RD_CYC),
    .WR_CYC(WR_CYC), .HOLD_CYC(HOLD_CYC), .TA_CYC(TA_CYC)
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .we_i      (we_i),
    .be_i      (be_i),
    .ready_o   (ready_o),
    .done_o    (done_o),
    .accept_o  (accept),
    .capture_o (capture),
    .sel_d_o   (sel_d),
    .sel_o     (sel),
    .we_o      (we_act),
    .oe_o      (oe_act),
    .drv_o     (drv)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (accept) addr_q <= addr_i;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    sram_lane #(.LANE_W(LANE_W)) u_lane (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .accept_i  (accept),
      .en_i      (be_i[l]),
      .wdata_i   (wdata_i[l*LANE_W +: LANE_W]),
      .capture_i (capture),
      .sel_d_i   (sel_d),
      .dq_i      (mem_dq_i[l*LANE_W +: LANE_W]),
      .bsel_n_o  (mem_be_no[l]),
      .wdata_o   (mem_dq_o[l*LANE_W +: LANE_W]),
      .rdata_o   (rdata_o[l*LANE_W +: LANE_W])
    );
  end

  assign mem_addr_o  = addr_q;
  assign mem_cs1_no  = !sel;
  assign mem_cs2_o   = sel;
  assign mem_we_no   = !we_act;
  assign mem_oe_no   = !oe_act;
  assign mem_dq_oe_o = drv;
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned LANES  = 2,
  parameter int unsigned TA_CYC = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic [LANES-1:0]  be_i,
  input logic              ready_o,
  input logic              done_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_cs1_no,
  input logic              mem_cs2_o,
  input logic              mem_we_no,
  input logic              mem_oe_no,
  input logic [LANES-1:0]  mem_be_no,
  input logic              mem_dq_oe_o
);
  localparam int unsigned GW = $clog2(TA_CYC + 1) + 1;
  logic [GW-1:0] gap_q;

  // cycles since output enable was last low, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 gap_q <= GW'(TA_CYC);
    else if (!mem_oe_no)         gap_q <= '0;
    else if (gap_q < GW'(TA_CYC)) gap_q <= gap_q + 1'b1;
  end

  assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (mem_cs1_no && !mem_cs2_o && mem_we_no && mem_oe_no &&
                 (&mem_be_no) && !mem_dq_oe_o));

  assert_wr_setup_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_we_no) |-> ($past(mem_dq_oe_o) && $past(!mem_cs1_no) && mem_dq_oe_o));

  assert_wr_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> (mem_dq_oe_o && !mem_cs1_no));

  assert_lane_used_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_cs1_no |-> !(&mem_be_no));

  assert_noop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && req_i && (be_i == '0)) |=> (done_o && ready_o && mem_cs1_no));

  assert_turn_gap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> (gap_q >= GW'(TA_CYC)));

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !req_i) |=> !done_o);

  assert_strobe_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!mem_we_no && !mem_oe_no));

  assert_addr_stable_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_cs1_no && $past(!mem_cs1_no)) |-> $stable(mem_addr_o));
endmodule

bind sram_ctrl sram_ctrl_chk #(
  .ADDR_W(ADDR_W), .LANES(LANES), .TA_CYC(TA_CYC)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .be_i        (be_i),
  .ready_o     (ready_o),
  .done_o      (done_o),
  .mem_addr_o  (mem_addr_o),
  .mem_cs1_no  (mem_cs1_no),
  .mem_cs2_o   (mem_cs2_o),
  .mem_we_no   (mem_we_no),
  .mem_oe_no   (mem_oe_no),
  .mem_be_no   (mem_be_no),
  .mem_dq_oe_o (mem_dq_oe_o)
);

// File: tb/sram_ctrl_tb.sv
module sram_ctrl_tb_top;
  localparam int CLK_NS = 10;
  localparam int RD  = (25 + CLK_NS - 1) / CLK_NS;
  localparam int WPA = (20 + CLK_NS - 1) / CLK_NS;
  localparam int DWA = (15 + CLK_NS - 1) / CLK_NS;
  localparam int WP  = (WPA > DWA) ? WPA : DWA;
  localparam int TA  = (12 + CLK_NS - 1) / CLK_NS;
  localparam int OE_CYC = (15 + CLK_NS - 1) / CLK_NS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [19:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [1:0]  be_in = '0;
  logic ready, done;
  logic [15:0] rdata;
  logic [19:0] m_addr;
  logic cs1_n, cs2, we_n, oe_n, dq_oe;
  logic [1:0] be_n;
  logic [15:0] dq_o, dq_in;

  int total = 0, bad = 0, float_cnt = 0, oe_cnt = 0;
  bit finished = 1'b0;
  logic [15:0] mem_m [256];
  logic [15:0] shadow [256];

  typedef struct {
    bit sel; bit we_n; bit oe_n; bit [1:0] be_n; bit dq_oe;
    bit ready; bit done; bit chk_rd; logic [15:0] rd;
    logic [19:0] addr; logic [15:0] wd; string dtag;
  } exp_t;
  exp_t exp_q[$];

  sram_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .be_i(be_in), .ready_o(ready), .done_o(done), .rdata_o(rdata),
    .mem_addr_o(m_addr), .mem_cs1_no(cs1_n), .mem_cs2_o(cs2), .mem_we_no(we_n),
    .mem_oe_no(oe_n), .mem_be_no(be_n), .mem_dq_o(dq_o), .mem_dq_oe_o(dq_oe),
    .mem_dq_i(dq_in)
  );

  initial forever #(CLK_NS / 2) clk = ~clk;

  // memory model: output valid only after output enable has been low OE_CYC edges
  always_comb begin
    logic rd_ok;
    logic [15:0] w;
    rd_ok = !cs1_n && cs2 && !oe_n && we_n && (oe_cnt >= OE_CYC);
    w = mem_m[m_addr[7:0]];
    dq_in = {(rd_ok && !be_n[1]) ? w[15:8] : 8'hEE, (rd_ok && !be_n[0]) ? w[7:0] : 8'hEE};
  end

  always @(posedge clk) begin
    if (!cs1_n && cs2 && !oe_n) oe_cnt <= oe_cnt + 1; else oe_cnt <= 0;
    if (!cs1_n && cs2 && !we_n && dq_oe) begin
      if (!be_n[0]) mem_m[m_addr[7:0]][7:0]  <= dq_o[7:0];
      if (!be_n[1]) mem_m[m_addr[7:0]][15:8] <= dq_o[15:8];
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", tag, what, act, expv, $time);
    end
  endtask

  function automatic exp_t idle_exp();
    exp_t e;
    e.sel = 0; e.we_n = 1; e.oe_n = 1; e.be_n = 2'b11; e.dq_oe = 0;
    e.ready = 1; e.done = 0; e.chk_rd = 0; e.rd = '0; e.addr = '0; e.wd = '0;
    e.dtag = "R9";
    return e;
  endfunction

  // reference comparison every cycle
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      exp_t e;
      e = (exp_q.size() != 0) ? exp_q.pop_front() : idle_exp();
      chk((cs1_n == !e.sel) && (cs2 == e.sel), "R2", "select", {cs1_n, cs2}, {!e.sel, e.sel});
      if (e.sel) chk(m_addr == e.addr, "R11", "address", m_addr, e.addr);
      chk(oe_n == e.oe_n, "R3", "oe_n", oe_n, e.oe_n);
      chk(we_n == e.we_n, "R4", "we_n", we_n, e.we_n);
      chk(!(!we_n && !oe_n), "R10", "strobe overlap", {we_n, oe_n}, 2'b11);
      chk(be_n == e.be_n, "R5", "lane selects", be_n, e.be_n);
      chk(dq_oe == e.dq_oe, "R7", "pad drive", dq_oe, e.dq_oe);
      if (dq_oe) chk(float_cnt == 0, "R7", "drive in float window", float_cnt, 0);
      if (e.dq_oe) chk(dq_o == e.wd, "R4", "write data", dq_o, e.wd);
      chk(ready == e.ready, "R8", "ready", ready, e.ready);
      chk(done == e.done, e.dtag, "done", done, e.done);
      if (e.chk_rd) chk(rdata == e.rd, "R3", "read data", rdata, e.rd);
      if (!oe_n) float_cnt = TA; else if (float_cnt > 0) float_cnt--;
    end
  end

  task automatic access(input bit wr, input logic [19:0] a, input logic [15:0] d,
                        input logic [1:0] bm, input bit poke);
    exp_t e;
    logic [15:0] r;
    @(negedge clk);
    while (!ready) @(negedge clk);
    #1;
    req = 1; we = wr; addr = a; wdata = d; be_in = bm;
    if (bm == 2'b00) begin
      e = idle_exp(); e.done = 1; e.dtag = "R6"; exp_q.push_back(e);
    end else begin
      e = idle_exp();
      e.sel = 1; e.be_n = ~bm; e.dq_oe = wr; e.ready = 0; e.addr = a; e.wd = d;
      exp_q.push_back(e);
      if (wr) begin
        for (int i = 0; i < WP; i++) begin e.we_n = 0; exp_q.push_back(e); end
        e.we_n = 1; exp_q.push_back(e);
        e = idle_exp(); e.done = 1; exp_q.push_back(e);
        if (bm[0]) shadow[a[7:0]][7:0]  = d[7:0];
        if (bm[1]) shadow[a[7:0]][15:8] = d[15:8];
      end else begin
        for (int i = 0; i < RD; i++) begin e.oe_n = 0; exp_q.push_back(e); end
        r = shadow[a[7:0]];
        e = idle_exp(); e.ready = 0; e.done = 1; e.chk_rd = 1;
        e.rd = {bm[1] ? r[15:8] : 8'h00, bm[0] ? r[7:0] : 8'h00};
        exp_q.push_back(e);
        for (int i = 1; i < TA; i++) begin
          e = idle_exp(); e.ready = 0; exp_q.push_back(e);
        end
      end
    end
    @(negedge clk); #1 req = 0;
    if (poke) begin  // R8: request while busy must be dropped
      @(negedge clk); #1;
      req = 1; we = 1; addr = a ^ 20'h1; wdata = 16'hDEAD; be_in = 2'b11;
      @(negedge clk); #1 req = 0;
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin mem_m[i] = '0; shadow[i] = '0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(ready && !done, "R1", "ready/done in reset", {ready, done}, 2'b10);
    chk(cs1_n && !cs2 && we_n && oe_n && (be_n == 2'b11) && !dq_oe, "R1", "pins in reset",
        {cs1_n, cs2, we_n, oe_n, be_n, dq_oe}, 7'b1011110);
    #1 rst_n = 1;
    @(negedge clk);
    chk(ready && cs1_n && !dq_oe, "R1", "after reset", {ready, cs1_n, dq_oe}, 3'b110);

    access(1, 20'h00010, 16'hA5C3, 2'b11, 0);   // R4 full write
    access(0, 20'h00010, 16'h0000, 2'b11, 0);   // R3 read after write
    access(1, 20'h00020, 16'h1234, 2'b01, 0);   // R5 low lane only
    access(1, 20'h00020, 16'hFF99, 2'b10, 0);   // R5 high lane only
    access(0, 20'h00020, 16'h0000, 2'b11, 0);
    access(0, 20'h00020, 16'h0000, 2'b01, 0);   // R3 masked lane reads zero
    access(0, 20'h00020, 16'h0000, 2'b10, 0);
    access(1, 20'h00010, 16'h7777, 2'b00, 0);   // R6 empty mask
    access(0, 20'h00010, 16'h0000, 2'b11, 0);   // R6 memory unchanged
    access(1, 20'h00031, 16'h5A5A, 2'b11, 0);
    access(1, 20'h00030, 16'h0F0F, 2'b11, 1);   // R8 poke during write
    access(0, 20'h00031, 16'h0000, 2'b11, 1);   // R8 poke during read
    access(0, 20'h00030, 16'h0000, 2'b11, 0);
    access(1, 20'hFFFFF, 16'hC001, 2'b11, 0);   // top address
    access(0, 20'hFFFFF, 16'h0000, 2'b11, 0);
    access(1, 20'hFFFFF, 16'h8118, 2'b10, 0);   // R7 write right after read
    access(0, 20'hFFFFF, 16'h0000, 2'b11, 0);
    access(1, 20'h00040, 16'h0000, 2'b00, 0);   // R6 back-to-back empty masks
    access(1, 20'h00040, 16'h0000, 2'b00, 0);
    access(0, 20'h00031, 16'h0000, 2'b11, 0);
    repeat (TA + 4) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog R8 act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule